// File: doc/BRIEF.md
# Lockable Dual Comparator Control Register

This block is a single 32-bit control and status register for a pair of analog comparators. Each comparator owns one 16-bit half. A half stores an enable, an input selector, a mode code, a hysteresis code, an output polarity and a 3-bit destination code. It also shows a live, synchronized copy of that comparator's result, and it has a lock bit that can be written once. The analog comparators and their hysteresis circuits sit outside the block. The stored hysteresis, mode and input-select fields are simply driven out on configuration ports.

The two raw comparator results pass through a two-flop synchronizer. Each synchronized result, inverted when the polarity bit is set, is steered onto exactly one of seven timer-facing lines picked by its destination code. The line is held low when the comparator is disabled. Setting a half's lock bit freezes every field of that half until the next synchronous reset. The other half stays writable.

Top module: `cmp_ctrl_reg`

## Requirements
- R1: After a synchronous reset, with both raw inputs low, the register reads 0x0000_0000, all route lines are low and all configuration outputs are 0.
- R2: The register responds only at byte address 0x1C. A read at any other address returns 0, and a write at any other address changes nothing.
- R3: The comparator 1 half (bits 15:0) and the comparator 2 half (bits 31:16) share one layout, given relative to the half: bit 15 lock, bit 14 result, bits 13:12 hysteresis, bit 11 polarity, bits 10:8 destination, bits 6:4 input select, bits 3:2 mode, bit 0 enable. In addition, comparator 1 uses half bit 1 as a switch control and comparator 2 uses half bit 7 as a window enable. Every writable field reads back what was last written.
- R4: Writing 1 to a half's lock bit (bit 15 or bit 31) locks that half. Later writes leave every bit of a locked half unchanged, including the lock bit itself, while writes to the unlocked half still take effect. Only a reset clears a lock.
- R5: Bit 14 and bit 30 read the synchronized raw result of comparator 1 and comparator 2 (1 = non-inverting input above inverting input). Bus writes to these bits are ignored.
- R6: Bit 7 and bit 17 are reserved. They always read 0 and ignore writes.
- R7: For a destination code k from 1 to 7, comparator c (0 for comparator 1, 1 for comparator 2) drives route_o[7*c + k - 1]. Code 0 drives no line. The codes, in order: 1 timer 1 break, 2 timer 1 capture 1, 3 timer 1 reference clear, 4 timer 2 capture 4, 5 timer 2 reference clear, 6 timer 3 capture 1, 7 timer 3 reference clear. All other lines of that comparator are low.
- R8: The selected route line carries the synchronized result XOR the polarity bit.
- R9: When a comparator's enable bit is 0, all seven of its route lines are low.
- R10: A change on a raw comparator input reaches the result bit and the route line after exactly two rising clock edges.
- R11: cfg_en_o, cfg_insel_o, cfg_mode_o and cfg_hyst_o carry the stored fields as {comparator 2, comparator 1}. cfg_window_o carries the comparator 2 window-enable bit and cfg_switch_o carries the comparator 1 switch-control bit.

Bus writes take effect on the rising edge where bus_we is high. Reads are combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data |
| cmp_raw | input | 2 | Raw comparator results, bit 0 = comparator 1 |
| route_o | output | 14 | One-hot timer routing, 7 lines per comparator |
| cfg_en_o | output | 2 | Enable bits |
| cfg_insel_o | output | 6 | Input select codes |
| cfg_mode_o | output | 4 | Mode codes |
| cfg_hyst_o | output | 4 | Hysteresis codes |
| cfg_window_o | output | 1 | Comparator 2 window enable |
| cfg_switch_o | output | 1 | Comparator 1 switch control |

## Verification
The hardest state to reach is a mixed one: one half locked while the other half is written in the same 32-bit access. Only that case shows whether the lock gating works per half and not for the whole word. The stimulus locks comparator 1 with a known setting. It then writes full words that try to clear the lock, change every field of that half and reprogram comparator 2. A second lock is then added, and a reset finally clears both locks. The routing is swept over every destination code and both polarity values for each comparator, with the other comparator disabled, so that a wrong line or a crossed half shows up.

// File: rtl/cmpctl_pkg.sv
package cmpctl_pkg;

    localparam int CSR_W       = 32;
    localparam int HALF_W      = 16;
    localparam int NUM_CMP     = 2;
    localparam int SEL_W       = 3;
    localparam int NUM_DEST    = (1 << SEL_W) - 1;
    localparam int SYNC_STAGES = 2;

    // Half-relative bit positions
    localparam int LOCK_BIT   = 15;
    localparam int RES_BIT    = 14;
    localparam int HYST_LO    = 12;
    localparam int POL_BIT    = 11;
    localparam int SEL_LO     = 8;
    localparam int WIN_BIT    = 7;
    localparam int INSEL_LO   = 4;
    localparam int MODE_LO    = 2;
    localparam int SW_BIT     = 1;
    localparam int EN_BIT     = 0;

    localparam logic [HALF_W-1:0] BASE_MASK = 16'hBF7D;

    typedef enum logic [SEL_W-1:0] {
        DEST_NONE    = 3'd0,
        DEST_T1_BRK  = 3'd1,
        DEST_T1_CAP1 = 3'd2,
        DEST_T1_CLR  = 3'd3,
        DEST_T2_CAP4 = 3'd4,
        DEST_T2_CLR  = 3'd5,
        DEST_T3_CAP1 = 3'd6,
        DEST_T3_CLR  = 3'd7
    } dest_e;

    typedef struct packed {
        logic        en;
        logic        extra;
        logic [2:0]  insel;
        logic [1:0]  mode;
        logic [1:0]  hyst;
        logic        pol;
        dest_e       dest;
    } cmp_cfg_t;

    function automatic logic [HALF_W-1:0] half_mask(input bit window_variant);
        logic [HALF_W-1:0] m;
        m = BASE_MASK;
        if (window_variant) m[WIN_BIT] = 1'b1;
        else                m[SW_BIT]  = 1'b1;
        return m;
    endfunction

    function automatic logic [NUM_DEST-1:0] steer(input dest_e d, input logic v);
        logic [NUM_DEST-1:0] r;
        r = '0;
        if (d != DEST_NONE) r[d - 3'd1] = v;
        return r;
    endfunction

endpackage

// File: rtl/cmp_sync.sv
module cmp_sync
    import cmpctl_pkg::*;
#(
    parameter int W = NUM_CMP
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] sync_o
);

    logic [SYNC_STAGES-1:0][W-1:0] stage_q;

    always_ff @(posedge clk) begin
        if (rst) stage_q <= '0;
        else begin
            stage_q[0] <= raw_i;
            for (int s = 1; s < SYNC_STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign sync_o = stage_q[SYNC_STAGES-1];

    // Cycles since reset, saturating, so the delay check never looks before reset
    logic [1:0] age_q;
    always_ff @(posedge clk) begin
        if (rst) age_q <= '0;
        else if (age_q != 2'd3) age_q <= age_q + 2'd1;
    end

    a_r10_two_edge_delay: assert property (@(posedge clk) disable iff (rst)
        (age_q >= 2'd2) |-> (sync_o == $past(raw_i, 2)))
        else $error("R10 synchronizer delay mismatch");

endmodule

// File: rtl/cmp_half.sv
module cmp_half
    import cmpctl_pkg::*;
#(
    parameter bit WINDOW_VARIANT = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_i,
    input  logic [HALF_W-1:0] wdata_i,
    input  logic              res_i,
    output logic [HALF_W-1:0] rd_o,
    output cmp_cfg_t          cfg_o
);

    localparam logic [HALF_W-1:0] WMASK = half_mask(WINDOW_VARIANT);

    logic [HALF_W-1:0] img_q;
    logic              locked;

    assign locked = img_q[LOCK_BIT];

    always_ff @(posedge clk) begin
        if (rst)                 img_q <= '0;
        else if (wr_i && !locked) img_q <= wdata_i & WMASK;
    end

    always_comb begin
        rd_o          = img_q;
        rd_o[RES_BIT] = res_i;
    end

    always_comb begin
        cfg_o.en    = img_q[EN_BIT];
        cfg_o.extra = WINDOW_VARIANT ? img_q[WIN_BIT] : img_q[SW_BIT];
        cfg_o.insel = img_q[INSEL_LO +: 3];
        cfg_o.mode  = img_q[MODE_LO +: 2];
        cfg_o.hyst  = img_q[HYST_LO +: 2];
        cfg_o.pol   = img_q[POL_BIT];
        cfg_o.dest  = dest_e'(img_q[SEL_LO +: SEL_W]);
    end

    a_r4_locked_half_frozen: assert property (@(posedge clk) disable iff (rst)
        locked |=> $stable(img_q))
        else $error("R4 locked half changed");

    a_r4_lock_sticky: assert property (@(posedge clk) disable iff (rst)
        !$fell(rd_o[LOCK_BIT]))
        else $error("R4 lock cleared without reset");

endmodule

// File: rtl/cmp_router.sv
module cmp_router
    import cmpctl_pkg::*;
(
    input  logic                en_i,
    input  logic                pol_i,
    input  dest_e               dest_i,
    input  logic                res_i,
    output logic [NUM_DEST-1:0] route_o
);

    logic level;
    assign level = res_i ^ pol_i;

    always_comb begin
        route_o = '0;
        if (en_i) route_o = steer(dest_i, level);
    end

    always_comb begin
        a_r7_route_onehot: assert ($onehot0(route_o))
            else $error("R7 more than one route line active");
    end

endmodule

// File: rtl/cmp_ctrl_reg.sv
module cmp_ctrl_reg
    import cmpctl_pkg::*;
#(
    parameter int          ADDR_W   = 8,
    parameter logic [7:0]  REG_ADDR = 8'h1C
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic                        bus_we,
    input  logic [CSR_W-1:0]            bus_wdata,
    output logic [CSR_W-1:0]            bus_rdata,
    input  logic [NUM_CMP-1:0]          cmp_raw,
    output logic [NUM_CMP*NUM_DEST-1:0] route_o,
    output logic [NUM_CMP-1:0]          cfg_en_o,
    output logic [NUM_CMP*3-1:0]        cfg_insel_o,
    output logic [NUM_CMP*2-1:0]        cfg_mode_o,
    output logic [NUM_CMP*2-1:0]        cfg_hyst_o,
    output logic                        cfg_window_o,
    output logic                        cfg_switch_o
);

    logic                     hit;
    logic [NUM_CMP-1:0]       res_sync;
    logic [CSR_W-1:0]         rd_img;
    cmp_cfg_t [NUM_CMP-1:0]   cfg;

    assign hit = (bus_addr == ADDR_W'(REG_ADDR));

    cmp_sync #(.W(NUM_CMP)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .raw_i  (cmp_raw),
        .sync_o (res_sync)
    );

    for (genvar c = 0; c < NUM_CMP; c++) begin : g_cmp
        cmp_half #(.WINDOW_VARIANT(c == 1)) u_half (
            .clk     (clk),
            .rst     (rst),
            .wr_i    (hit && bus_we),
            .wdata_i (bus_wdata[c*HALF_W +: HALF_W]),
            .res_i   (res_sync[c]),
            .rd_o    (rd_img[c*HALF_W +: HALF_W]),
            .cfg_o   (cfg[c])
        );

        cmp_router u_router (
            .en_i    (cfg[c].en),
            .pol_i   (cfg[c].pol),
            .dest_i  (cfg[c].dest),
            .res_i   (res_sync[c]),
            .route_o (route_o[c*NUM_DEST +: NUM_DEST])
        );

        assign cfg_en_o[c]          = cfg[c].en;
        assign cfg_insel_o[c*3 +: 3] = cfg[c].insel;
        assign cfg_mode_o[c*2 +: 2]  = cfg[c].mode;
        assign cfg_hyst_o[c*2 +: 2]  = cfg[c].hyst;

        a_r9_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
            !cfg_en_o[c] |-> (route_o[c*NUM_DEST +: NUM_DEST] == '0))
            else $error("R9 disabled comparator drives a route line");
    end

    assign cfg_window_o = cfg[1].extra;
    assign cfg_switch_o = cfg[0].extra;

    assign bus_rdata = hit ? rd_img : '0;

    a_r5_result_mirror: assert property (@(posedge clk) disable iff (rst)
        hit |-> (bus_rdata[RES_BIT] == res_sync[0] &&
                 bus_rdata[HALF_W + RES_BIT] == res_sync[1]))
        else $error("R5 result bit does not follow synchronizer");

    a_r2_miss_write_ignored: assert property (@(posedge clk) disable iff (rst)
        (bus_we && !hit) |=> $stable({cfg_en_o, cfg_insel_o, cfg_mode_o,
                                      cfg_hyst_o, cfg_window_o, cfg_switch_o}))
        else $error("R2 write at foreign address changed configuration");

    a_r6_reserved_low: assert property (@(posedge clk) disable iff (rst)
        !bus_rdata[7] && !bus_rdata[17])
        else $error("R6 reserved bit read as one");

endmodule

// File: tb/cmp_ctrl_reg_bench.sv
`timescale 1ns/1ps
module cmp_ctrl_reg_bench;

    localparam logic [31:0] WMASK = 32'hBFFD_BF7F;
    localparam logic [7:0]  CSR   = 8'h1C;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = 8'h00;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  cmp_raw = 2'b00;
    logic [13:0] route_o;
    logic [1:0]  cfg_en_o;
    logic [5:0]  cfg_insel_o;
    logic [3:0]  cfg_mode_o;
    logic [3:0]  cfg_hyst_o;
    logic        cfg_window_o;
    logic        cfg_switch_o;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    cmp_ctrl_reg u_cmp_ctrl_reg (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cmp_raw(cmp_raw),
        .route_o(route_o), .cfg_en_o(cfg_en_o), .cfg_insel_o(cfg_insel_o),
        .cfg_mode_o(cfg_mode_o), .cfg_hyst_o(cfg_hyst_o),
        .cfg_window_o(cfg_window_o), .cfg_switch_o(cfg_switch_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic set_raw(input logic [1:0] v);
        @(negedge clk); cmp_raw = v;
        @(negedge clk); @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
    endtask

    function automatic logic [6:0] exp_route(input logic [2:0] sel, input logic v);
        logic [6:0] r = '0;
        if (sel != 0) r[sel - 1] = v;
        return r;
    endfunction

    // R1
    task automatic t_reset();
        logic [31:0] d;
        do_reset();
        bus_read(CSR, d);
        chk("R1 register after reset", d, 32'h0);
        chk("R1 routes after reset", {18'h0, route_o}, 32'h0);
        chk("R1 config after reset",
            {12'h0, cfg_en_o, cfg_insel_o, cfg_mode_o, cfg_hyst_o, cfg_window_o, cfg_switch_o}, 32'h0);
    endtask

    // R3, R11
    task automatic t_fields();
        logic [31:0] pats [3] = '{32'h7FFF_7FFF, 32'h2A55_1AA6, 32'h15AA_25D9};
        logic [31:0] d, e;
        foreach (pats[i]) begin
            bus_write(CSR, pats[i] & 32'h7FFF_7FFF);
            e = pats[i] & 32'h7FFF_7FFF & WMASK;
            bus_read(CSR, d);
            chk("R3 field readback", d, e);
            chk("R11 enable export", {30'h0, cfg_en_o}, {30'h0, e[16], e[0]});
            chk("R11 input select export", {26'h0, cfg_insel_o}, {26'h0, e[22:20], e[6:4]});
            chk("R11 mode export", {28'h0, cfg_mode_o}, {28'h0, e[19:18], e[3:2]});
            chk("R11 hysteresis export", {28'h0, cfg_hyst_o}, {28'h0, e[29:28], e[13:12]});
            chk("R11 window and switch export", {30'h0, cfg_window_o, cfg_switch_o}, {30'h0, e[23], e[1]});
        end
    endtask

    // R2
    task automatic t_address();
        logic [31:0] d;
        bus_write(CSR, 32'h0000_0000);
        bus_write(8'h18, 32'h0123_0321);
        bus_write(8'h1D, 32'h0001_0001);
        bus_read(CSR, d);
        chk("R2 foreign write ignored", d, 32'h0);
        bus_write(CSR, 32'h0001_0001);
        bus_read(8'h18, d);
        chk("R2 foreign read is zero", d, 32'h0);
    endtask

    // R5, R6
    task automatic t_reserved_mirror();
        logic [31:0] d;
        set_raw(2'b00);
        bus_write(CSR, 32'h4002_4080);
        bus_read(CSR, d);
        chk("R6 reserved and R5 result bits ignore writes", d & 32'h4002_4080, 32'h0000_0000);
        set_raw(2'b01);
        bus_read(CSR, d);
        chk("R5 comparator 1 result bit", {30'h0, d[30], d[14]}, 32'h1);
        set_raw(2'b10);
        bus_read(CSR, d);
        chk("R5 comparator 2 result bit", {30'h0, d[30], d[14]}, 32'h2);
        set_raw(2'b00);
    endtask

    // R10
    task automatic t_sync();
        logic [31:0] d;
        bus_write(CSR, 32'h0000_0101);  // comparator 1 enabled, dest 1
        @(negedge clk); cmp_raw = 2'b01;
        @(negedge clk); bus_addr = CSR; #1 d = bus_rdata;
        chk("R10 not visible after one edge", {31'h0, d[14]}, 32'h0);
        chk("R10 route not yet active", {31'h0, route_o[0]}, 32'h0);
        @(negedge clk); #1 d = bus_rdata;
        chk("R10 visible after two edges", {31'h0, d[14]}, 32'h1);
        chk("R10 route active after two edges", {31'h0, route_o[0]}, 32'h1);
        set_raw(2'b00);
    endtask

    // R7, R8
    task automatic t_route();
        for (int c = 0; c < 2; c++) begin
            for (int r = 0; r < 2; r++) begin
                set_raw(r[0] ? 2'b11 : 2'b00);
                for (int s = 0; s < 8; s++) begin
                    for (int p = 0; p < 2; p++) begin
                        logic [15:0] h = 16'h0001 | (16'(s) << 8) | (16'(p) << 11);
                        logic [13:0] e = '0;
                        bus_write(CSR, c == 0 ? {16'h0, h} : {h, 16'h0});
                        if (c == 0) e[6:0]  = exp_route(3'(s), r[0] ^ p[0]);
                        else        e[13:7] = exp_route(3'(s), r[0] ^ p[0]);
                        chk("R7 R8 destination steering and polarity", {18'h0, route_o}, {18'h0, e});
                    end
                end
            end
        end
        set_raw(2'b00);
    endtask

    // R9
    task automatic t_enable();
        set_raw(2'b11);
        bus_write(CSR, 32'h0100_0100);
        chk("R9 disabled with high result", {18'h0, route_o}, 32'h0);
        bus_write(CSR, 32'h0F00_0F00);
        chk("R9 disabled with polarity set", {18'h0, route_o}, 32'h0);
        set_raw(2'b00);
    endtask

    // R4
    task automatic t_lock();
        logic [31:0] d;
        bus_write(CSR, 32'h0000_8A35);           // lock comparator 1
        bus_write(CSR, 32'h2231_0000);           // try clear lock, reprogram both
        bus_read(CSR, d);
        chk("R4 locked half frozen, other half written", d, 32'h2231_8A35);
        bus_write(CSR, 32'h0000_7FFF);
        bus_read(CSR, d);
        chk("R4 lock survives write of zero", d[15:0], 32'h8A35);
        chk("R4 unlocked half still writable", d[31:16], 32'h0);
        bus_write(CSR, 32'h9355_0000);           // lock comparator 2
        bus_write(CSR, 32'h0000_0000);
        bus_read(CSR, d);
        chk("R4 both halves locked", d, 32'h9355_8A35);
        do_reset();
        bus_read(CSR, d);
        chk("R4 reset clears locks", d, 32'h0);
        bus_write(CSR, 32'h0001_0001);
        bus_read(CSR, d);
        chk("R4 writable after reset", d, 32'h0001_0001);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        t_reset();
        t_fields();
        t_address();
        t_reserved_mirror();
        t_sync();
        t_route();
        t_enable();
        t_lock();
        summary();
    end

    initial begin
        #(8 * 100000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
    end

endmodule